// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Receiver

This block recovers character frames from one asynchronous serial line. The line is oversampled by the system clock, and a run-time divisor gives the number of clock cycles per bit. The incoming line first passes through a two-flop synchronizer and an optional polarity inversion. A falling edge seen while the receiver is idle begins a frame. After that, the start bit, each data bit, an optional parity bit and the first stop bit are each sampled once, near the middle of the bit.

Run-time configuration inputs select the following:
- a data length of 5 to 9 bits;
- a parity mode: none, odd, even, forced zero or forced one;
- whether parity errors are reported;
- whether the first received data bit is the least or the most significant bit;
- whether the line is inverted.

For each frame that passes its start-bit check, the block reports one thing: a 9-bit right-aligned data word with a one-clock valid strobe. A parity-error flag and a framing-error flag go with the strobe. A start bit found high at its sampling point aborts the frame instead. It raises a separate one-clock start-error flag and sends the receiver back to idle.

Top module: `uart_frame_rx`

## Requirements
- R1: After reset, `valid_o`, `par_err_o`, `frame_err_o` and `start_err_o` are low and `data_o` is zero. They stay so while the line idles at its inactive level.
- R2: A frame is started by a falling edge of the logical line while idle. The sampling point of bit n is floor(`div_i`/2) cycles after the edge plus n·`div_i` cycles, where n=0 is the start bit. In LSB-first order (`cfg_msb_first_i`=0), the first data bit lands in `data_o[0]`. `valid_o` is high for exactly one clock per accepted frame.
- R3: `cfg_nbits_i` (values 5..9) sets the number of data bits. The word is right-aligned, and `data_o` bits at and above that count are 0.
- R4: With `cfg_msb_first_i`=1, the first data bit received lands in `data_o[N-1]` and the last in `data_o[0]`.
- R5: With `rx_invert_i`=1, the line is complemented before edge detection and sampling. Idle is then a low level, and a 0 data bit is a high level.
- R6: If the start bit is high at its sampling point, `start_err_o` pulses for one clock, no `valid_o` is produced, and the receiver waits for the next falling edge.
- R7: `cfg_parity_i` code 1 is odd and code 2 is even. The parity bit follows the last data bit. `par_err_o` is raised with `valid_o` when the count of ones in the data plus the parity bit is even (odd mode) or odd (even mode).
- R8: Codes 3 and 4 force the parity bit. `par_err_o` is raised when the received parity bit is not 0 (code 3) or not 1 (code 4).
- R9: Code 0 (or any code above 4) means no parity bit: the stop bit is sampled directly after the last data bit. As a result, the strobe arrives one bit period earlier than with parity.
- R10: A stop bit sampled low raises `frame_err_o` together with `valid_o`, and the received data is still reported.
- R11: With `cfg_par_check_i`=0, `par_err_o` stays low. Frame timing is unchanged: the strobe arrives in the same cycle as with checking enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the line |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_line_i | input | 1 | Asynchronous serial input line |
| rx_invert_i | input | 1 | 1 = complement the line before use |
| div_i | input | DIV_W (16) | Clock cycles per bit, at least 2 |
| cfg_nbits_i | input | 4 | Data bits per frame, 5..9 (clamped) |
| cfg_parity_i | input | 3 | 0 none, 1 odd, 2 even, 3 forced 0, 4 forced 1 |
| cfg_par_check_i | input | 1 | 1 = report parity mismatches |
| cfg_msb_first_i | input | 1 | 1 = first data bit is the MSB |
| data_o | output | MAX_BITS (9) | Received word, right-aligned, held until the next frame |
| valid_o | output | 1 | One-clock strobe for a completed frame |
| par_err_o | output | 1 | Parity mismatch, with `valid_o` |
| frame_err_o | output | 1 | Stop bit sampled low, with `valid_o` |
| start_err_o | output | 1 | Start bit not low at mid-bit, frame dropped |

## Verification
Every result appears one clock after the stop-bit sampling point (or after the start-bit sampling point, for the start error). That sampling point lies two synchronizer stages plus one edge register plus floor(div/2) cycles after the falling edge, and a further whole number of bit periods after it. The bench does not predict that exact cycle. A negative-edge monitor counts and captures every strobe and flag. Each frame task then idles the line for three bit periods, which is well past the due cycle, before comparing the captured values. The timing requirements are checked by recording the cycle number of each strobe relative to its frame start: the parity-frame and no-parity-frame offsets must differ by exactly one bit period, and the offsets with checking on and off must be equal.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    PAR_NONE = 3'd0,
    PAR_ODD  = 3'd1,
    PAR_EVEN = 3'd2,
    PAR_ZERO = 3'd3,
    PAR_ONE  = 3'd4
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

endpackage

// File: rtl/uart_rx_front.sv
module uart_rx_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic invert_i,
  output logic level_o,
  output logic fall_o
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;

  // shift chain of synchronizer flops
  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], line_i};
  end

  assign level_o = sync_q[SYNC_STAGES-1] ^ invert_i;

  always_comb begin
    prev_d = level_o;
  end

  assign fall_o = prev_q & ~level_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

endmodule

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             load_i,
  input  logic             run_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load_i | run_i;
  assign tick_o = run_i & ~load_i & (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = div_i >> 1;
    end else if (run_i) begin
      if (cnt_q == '0) cnt_d = div_i - DIV_W'(1);
      else             cnt_d = cnt_q - DIV_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < div_i)); // R2

endmodule

// File: rtl/uart_rx_shift.sv
module uart_rx_shift #(
  parameter int MAX_BITS = 9,
  localparam int NB_W = $clog2(MAX_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                shift_i,
  input  logic                bit_i,
  input  logic                msb_first_i,
  input  logic [NB_W-1:0]     nbits_i,
  output logic [MAX_BITS-1:0] word_o
);

  logic [MAX_BITS-1:0] sh_q, sh_d;
  logic [MAX_BITS-1:0] mask;
  logic [MAX_BITS-1:0] lsb_word;
  logic                sh_en;

  assign sh_en = clear_i | shift_i;

  always_comb begin
    sh_d = sh_q;
    if (clear_i) begin
      sh_d = '0;
    end else if (shift_i) begin
      if (msb_first_i) sh_d = {sh_q[MAX_BITS-2:0], bit_i};
      else             sh_d = {bit_i, sh_q[MAX_BITS-1:1]};
    end
  end

  for (genvar i = 0; i < MAX_BITS; i++) begin : g_mask
    assign mask[i] = (NB_W'(i) < nbits_i);
  end

  assign lsb_word = sh_q >> (NB_W'(MAX_BITS) - nbits_i);
  assign word_o   = msb_first_i ? (sh_q & mask) : lsb_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
    end else if (sh_en) begin
      sh_q <= sh_d;
    end
  end

endmodule

// File: rtl/uart_rx_parity.sv
module uart_rx_parity
  import uart_rx_pkg::*;
#(
  parameter int MAX_BITS = 9
) (
  input  logic [2:0]          mode_i,
  input  logic [MAX_BITS-1:0] word_i,
  input  logic                pbit_i,
  output logic                used_o,
  output logic                ok_o
);

  par_mode_e mode;
  logic      odd_total;

  assign mode      = par_mode_e'(mode_i);
  assign odd_total = (^word_i) ^ pbit_i;

  always_comb begin
    used_o = 1'b1;
    ok_o   = 1'b1;
    case (mode)
      PAR_ODD:  ok_o = odd_total;
      PAR_EVEN: ok_o = ~odd_total;
      PAR_ZERO: ok_o = ~pbit_i;
      PAR_ONE:  ok_o = pbit_i;
      default:  used_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
  import uart_rx_pkg::*;
#(
  parameter int MAX_BITS    = 9,
  parameter int MIN_BITS    = 5,
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int NB_W = $clog2(MAX_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_line_i,
  input  logic                rx_invert_i,
  input  logic [DIV_W-1:0]    div_i,
  input  logic [NB_W-1:0]     cfg_nbits_i,
  input  logic [2:0]          cfg_parity_i,
  input  logic                cfg_par_check_i,
  input  logic                cfg_msb_first_i,
  output logic [MAX_BITS-1:0] data_o,
  output logic                valid_o,
  output logic                par_err_o,
  output logic                frame_err_o,
  output logic                start_err_o
);

  rx_state_e           state_q, state_d;
  logic [NB_W-1:0]     bitcnt_q, bitcnt_d;
  logic [NB_W-1:0]     bitcnt_inc;
  logic [NB_W-1:0]     nbits_eff;
  logic                pbit_q, pbit_d;
  logic                level, fall, tick, run;
  logic                load, shift, done, serr_d;
  logic                par_used, par_ok;
  logic [MAX_BITS-1:0] word;
  logic [MAX_BITS-1:0] data_q;
  logic                valid_q, perr_q, ferr_q, serr_q;
  logic                valid_d, perr_d, ferr_d;

  // clamp the configured length into the supported range
  always_comb begin
    if (cfg_nbits_i < NB_W'(MIN_BITS))      nbits_eff = NB_W'(MIN_BITS);
    else if (cfg_nbits_i > NB_W'(MAX_BITS)) nbits_eff = NB_W'(MAX_BITS);
    else                                    nbits_eff = cfg_nbits_i;
  end

  uart_rx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .line_i   (rx_line_i),
    .invert_i (rx_invert_i),
    .level_o  (level),
    .fall_o   (fall)
  );

  uart_rx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (div_i),
    .load_i (load),
    .run_i  (run),
    .tick_o (tick)
  );

  uart_rx_shift #(.MAX_BITS(MAX_BITS)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (load),
    .shift_i     (shift),
    .bit_i       (level),
    .msb_first_i (cfg_msb_first_i),
    .nbits_i     (nbits_eff),
    .word_o      (word)
  );

  uart_rx_parity #(.MAX_BITS(MAX_BITS)) u_parity (
    .mode_i (cfg_parity_i),
    .word_i (word),
    .pbit_i (pbit_q),
    .used_o (par_used),
    .ok_o   (par_ok)
  );

  assign run        = (state_q != ST_IDLE);
  assign bitcnt_inc = bitcnt_q + NB_W'(1);

  // next-state process
  always_comb begin
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    pbit_d   = pbit_q;
    load     = 1'b0;
    shift    = 1'b0;
    done     = 1'b0;
    serr_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (fall) begin
          state_d = ST_START;
          load    = 1'b1;
        end
      end
      ST_START: begin
        if (tick) begin
          if (level) begin
            state_d = ST_IDLE;
            serr_d  = 1'b1;
          end else begin
            state_d  = ST_DATA;
            bitcnt_d = '0;
          end
        end
      end
      ST_DATA: begin
        if (tick) begin
          shift    = 1'b1;
          bitcnt_d = bitcnt_inc;
          if (bitcnt_inc == nbits_eff) begin
            state_d = par_used ? ST_PAR : ST_STOP;
          end
        end
      end
      ST_PAR: begin
        if (tick) begin
          pbit_d  = level;
          state_d = ST_STOP;
        end
      end
      ST_STOP: begin
        if (tick) begin
          done    = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // result next values
  always_comb begin
    valid_d = done;
    perr_d  = done & par_used & cfg_par_check_i & ~par_ok;
    ferr_d  = done & ~level;
  end

  // register process
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      pbit_q   <= 1'b0;
      data_q   <= '0;
      valid_q  <= 1'b0;
      perr_q   <= 1'b0;
      ferr_q   <= 1'b0;
      serr_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      pbit_q   <= pbit_d;
      valid_q  <= valid_d;
      perr_q   <= perr_d;
      ferr_q   <= ferr_d;
      serr_q   <= serr_d;
      if (done) begin
        data_q <= word;
      end
    end
  end

  assign data_o      = data_q;
  assign valid_o     = valid_q;
  assign par_err_o   = perr_q;
  assign frame_err_o = ferr_q;
  assign start_err_o = serr_q;

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R2
  AST_DATA_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((data_o >> nbits_eff) == '0)); // R3
  AST_SERR_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_err_o |-> !valid_o); // R6
  AST_PERR_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_o |-> valid_o); // R7
  AST_FERR_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> valid_o); // R10
  AST_PERR_CHECK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_par_check_i && $stable(cfg_par_check_i)) |-> !par_err_o); // R11

endmodule

// File: tb/uart_frame_rx_bench.sv
module uart_frame_rx_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line = 1'b1;
  logic        inv_r = 1'b0;
  logic [15:0] div_r = 16'(DIV);
  logic [3:0]  nbits_r = 4'd8;
  logic [2:0]  par_r = 3'd0;
  logic        chk_r = 1'b1;
  logic        msb_r = 1'b0;
  logic [8:0]  data_o;
  logic        valid_o, par_err_o, frame_err_o, start_err_o;

  int n_checks = 0;
  int n_err    = 0;
  int cyc      = 0;
  int n_valid, n_serr, width_err, valid_cyc, start_cyc;
  logic [8:0] cap_data;
  logic       cap_perr, cap_ferr;
  logic       prev_valid = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_frame_rx u_uart_frame_rx (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .rx_line_i       (line),
    .rx_invert_i     (inv_r),
    .div_i           (div_r),
    .cfg_nbits_i     (nbits_r),
    .cfg_parity_i    (par_r),
    .cfg_par_check_i (chk_r),
    .cfg_msb_first_i (msb_r),
    .data_o          (data_o),
    .valid_o         (valid_o),
    .par_err_o       (par_err_o),
    .frame_err_o     (frame_err_o),
    .start_err_o     (start_err_o)
  );

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (valid_o) begin
      n_valid++;
      cap_data  = data_o;
      cap_perr  = par_err_o;
      cap_ferr  = frame_err_o;
      valid_cyc = cyc;
      if (prev_valid) width_err++;
    end
    prev_valid = valid_o;
    if (start_err_o) n_serr++;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic exp_perr(input logic [8:0] d, input logic [2:0] pm,
                                    input logic pb, input logic chkon);
    int  ones = $countones(d) + int'(pb);
    logic bad = 1'b0;
    case (pm)
      3'd1: bad = ((ones % 2) != 1);
      3'd2: bad = ((ones % 2) != 0);
      3'd3: bad = pb;
      3'd4: bad = !pb;
      default: bad = 1'b0;
    endcase
    return chkon & bad;
  endfunction

  task automatic drive_bit(input logic b);
    line = b ^ inv_r;
    repeat (DIV) @(negedge clk);
  endtask

  task automatic clear_caps();
    n_valid = 0; n_serr = 0; width_err = 0;
    cap_data = '0; cap_perr = 1'b0; cap_ferr = 1'b0;
  endtask

  task automatic send_frame(input logic [8:0] d, input int nb, input logic msb,
                            input logic [2:0] pm, input logic pchk, input logic pb,
                            input logic sb, input logic inv);
    if (inv != inv_r) begin
      inv_r = inv;
      line  = ~inv;
      repeat (3 * DIV) @(negedge clk);
    end
    nbits_r = 4'(nb);
    par_r   = pm;
    chk_r   = pchk;
    msb_r   = msb;
    @(negedge clk);
    clear_caps();
    start_cyc = cyc;
    drive_bit(1'b0);
    for (int i = 0; i < nb; i++) drive_bit(msb ? d[nb-1-i] : d[i]);
    if (pm >= 3'd1 && pm <= 3'd4) drive_bit(pb);
    drive_bit(sb);
    repeat (3) drive_bit(1'b1);
  endtask

  task automatic check_frame(input string req, input logic [8:0] ed,
                             input logic epe, input logic efe);
    chk(req, "valid count", n_valid, 1);
    chk(req, "strobe width errors", width_err, 0);
    chk(req, "data", int'(cap_data), int'(ed));
    chk(req, "parity error", int'(cap_perr), int'(epe));
    chk(req, "framing error", int'(cap_ferr), int'(efe));
    chk(req, "start error count", n_serr, 0);
  endtask

  // R1: reset state and quiet idle line
  task automatic t_reset();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    clear_caps();
    repeat (4 * DIV) @(negedge clk);
    chk("R1", "valid", int'(valid_o), 0);
    chk("R1", "data", int'(data_o), 0);
    chk("R1", "flags", int'({par_err_o, frame_err_o, start_err_o}), 0);
    chk("R1", "strobes while idle", n_valid + n_serr, 0);
  endtask

  // R2: LSB-first 8-bit words
  task automatic t_lsb();
    send_frame(9'h0A5, 8, 1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0);
    check_frame("R2", 9'h0A5, 1'b0, 1'b0);
    send_frame(9'h03C, 8, 1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0);
    check_frame("R2", 9'h03C, 1'b0, 1'b0);
  endtask

  // R3: other data lengths
  task automatic t_lengths();
    send_frame(9'h015, 5, 1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0);
    check_frame("R3", 9'h015, 1'b0, 1'b0);
    send_frame(9'h1A3, 9, 1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0);
    check_frame("R3", 9'h1A3, 1'b0, 1'b0);
    send_frame(9'h05B, 7, 1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0);
    check_frame("R3", 9'h05B, 1'b0, 1'b0);
  endtask

  // R4: MSB-first ordering
  task automatic t_msb();
    send_frame(9'h0C1, 8, 1'b1, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0);
    check_frame("R4", 9'h0C1, 1'b0, 1'b0);
    send_frame(9'h02D, 6, 1'b1, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0);
    check_frame("R4", 9'h02D, 1'b0, 1'b0);
  endtask

  // R5: inverted line
  task automatic t_invert();
    send_frame(9'h05A, 8, 1'b0, 3'd2, 1'b1, 1'b0, 1'b1, 1'b1);
    check_frame("R5", 9'h05A, 1'b0, 1'b0);
    send_frame(9'h1F0, 9, 1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 1'b1);
    check_frame("R5", 9'h1F0, 1'b0, 1'b0);
    send_frame(9'h000, 8, 1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0);
    check_frame("R5", 9'h000, 1'b0, 1'b0);
  endtask

  // R6: short low glitch rejected, next frame accepted
  task automatic t_start_err();
    @(negedge clk);
    clear_caps();
    line = 1'b0;
    repeat (4) @(negedge clk);
    line = 1'b1;
    repeat (3 * DIV) @(negedge clk);
    chk("R6", "start error count", n_serr, 1);
    chk("R6", "valid count", n_valid, 0);
    send_frame(9'h081, 8, 1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0);
    check_frame("R6", 9'h081, 1'b0, 1'b0);
  endtask

  // R7 / R8: parity modes with good and bad parity bits
  task automatic t_parity(input string req, input logic [2:0] pm, input logic [8:0] d);
    for (int p = 0; p < 2; p++) begin
      send_frame(d, 8, 1'b0, pm, 1'b1, p[0], 1'b1, 1'b0);
      check_frame(req, d, exp_perr(d, pm, p[0], 1'b1), 1'b0);
    end
  endtask

  // R9 / R11: timing with and without parity, with and without checking
  task automatic t_timing();
    int off_none, off_par, off_nochk;
    send_frame(9'h096, 8, 1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0);
    check_frame("R9", 9'h096, 1'b0, 1'b0);
    off_none = valid_cyc - start_cyc;
    send_frame(9'h096, 8, 1'b0, 3'd1, 1'b1, 1'b1, 1'b1, 1'b0);
    check_frame("R9", 9'h096, 1'b0, 1'b0);
    off_par = valid_cyc - start_cyc;
    chk("R9", "strobe offset parity minus none", off_par - off_none, DIV);
    send_frame(9'h096, 8, 1'b0, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0);
    check_frame("R11", 9'h096, 1'b0, 1'b0);
    off_nochk = valid_cyc - start_cyc;
    chk("R11", "strobe offset check off vs on", off_nochk, off_par);
    send_frame(9'h011, 8, 1'b0, 3'd4, 1'b0, 1'b0, 1'b1, 1'b0);
    check_frame("R11", 9'h011, 1'b0, 1'b0);
  endtask

  // R10: low stop bit
  task automatic t_stop_err();
    send_frame(9'h0E7, 8, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    check_frame("R10", 9'h0E7, 1'b0, 1'b1);
    send_frame(9'h024, 8, 1'b0, 3'd2, 1'b1, 1'b0, 1'b1, 1'b0);
    check_frame("R10", 9'h024, 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_lsb();
    t_lengths();
    t_msb();
    t_invert();
    t_start_err();
    t_parity("R7", 3'd1, 9'h0B3);
    t_parity("R7", 3'd2, 9'h0B3);
    t_parity("R7", 3'd2, 9'h0B2);
    t_parity("R8", 3'd3, 9'h04F);
    t_parity("R8", 3'd4, 9'h04F);
    t_timing();
    t_stop_err();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule